// File: doc/BRIEF.md
# Programmable Interval Timer With Interrupt

The block is a 24-bit event and interval counter that sits on a narrow byte-wide register bus and uses four byte addresses. Software loads a reload value one byte at a time, then writes a control byte. That byte picks the clock source, the count direction, reload behaviour, interrupt enable and the level of an output pin. The counter advances on single-cycle ticks. A tick comes either from a free-running prescaler that divides the system clock by 16 or by 256, or from a chosen edge of an external input. The external input is synchronized inside the block.

When a tick brings the counter to zero, that is a terminal count. A terminal count sets a pending flag, toggles the output pin and, if auto-reload is on, loads the reload value into the counter instead of zero. The interrupt output is the pending flag gated by the enable bit. Reading the status address acknowledges the interrupt. The block suits periodic interrupts, timeouts and counting of external events.

Top module: `interval_timer`

## Requirements
- R1: After reset the counter, the reload value and all control state are zero. Every register read returns 0x00, and `pinOut` and `irqOut` are low.
- R2: A bus write to address 0, 1 or 2 sets the low, middle or high byte of the reload value. Such a write leaves the live counter unchanged.
- R3: A read of address 0, 1 or 2 returns the low, middle or high byte of the live counter. The read data is combinational on `busAddr`.
- R4: Writing address 3 with bit 6 set copies the reload value into the counter on that clock edge, and this takes priority over any tick. Bit 6 is not stored and never reads back.
- R5: Control bits {4,0} select the tick source: 00 is the system clock divided by 16, 10 is the system clock divided by 256, 01 is rising edges of `extClkIn`, and 11 is falling edges. Every control write restarts the prescaler, so with a divided source the counter first changes 16 (or 256) cycles after the write edge, and then on every further period.
- R6: `extClkIn` passes through a two-flop synchronizer and an edge detector. In an external mode, a change of the pin is counted at the third clock edge after it, and the edge of the opposite sense is ignored.
- R7: Control bit 3 selects the direction: 1 counts up, 0 counts down. Counting up wraps from 0xFFFFFF to 0x000000.
- R8: A terminal count is a tick whose result is zero. With control bit 5 set, the counter then loads the reload value. With bit 5 clear, it holds zero and keeps counting on later ticks.
- R9: A control write drives `pinOut` to bit 2 of the written byte. Each terminal count outside a control write toggles `pinOut`.
- R10: A terminal count sets the pending flag whatever the value of the enable bit. `irqOut` is high exactly when control bit 7 and the pending flag are both set.
- R11: A read of address 3 returns the enable bit in bit 7, the pending flag in bit 0 and zeros elsewhere. The read clears the pending flag on the following edge.
- R12: If a status read and a terminal count fall in the same cycle, the pending flag is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register byte address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe; at address 3 it acknowledges the interrupt |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for the current address |
| extClkIn | input | 1 | Asynchronous external count input |
| pinOut | output | 1 | Output pin that toggles on terminal count |
| irqOut | output | 1 | Level interrupt request |

## Verification
If the counter or reload state is wrong, it shows up on the first byte read after the next tick, or one period later as a terminal count that arrives early or late. That in turn shifts the toggle of `pinOut` and the rise of `irqOut` by whole tick periods. A wrong pending flag shows up at once on `irqOut` and in bit 0 of the next status read. A prescaler or synchronizer that is off by one moves the counter's change by a cycle. The bench therefore reads the counter at cycle-exact points around each expected tick and forces a status read into the very cycle of a terminal count.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd3;

  // control byte bit positions (status read reuses 7 and 0)
  localparam int BIT_IRQ_EN   = 7;
  localparam int BIT_LOAD_NOW = 6;
  localparam int BIT_AUTO     = 5;
  localparam int BIT_SEL_HI   = 4;
  localparam int BIT_UP       = 3;
  localparam int BIT_PIN      = 2;
  localparam int BIT_SEL_LO   = 0;

  typedef enum logic [1:0] {
    SEL_DIV_LO   = 2'b00,
    SEL_EXT_RISE = 2'b01,
    SEL_DIV_HI   = 2'b10,
    SEL_EXT_FALL = 2'b11
  } clk_sel_e;

  typedef struct packed {
    logic     irqEn;
    logic     loadNow;
    logic     autoReload;
    logic     countUp;
    logic     pinLevel;
    clk_sel_e clkSel;
  } ctrl_fields_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              tick;
    logic              loadNow;
    logic              countUp;
    logic              autoReload;
    logic              reloadWr;
    logic [ADDR_W-1:0] byteSel;
  } strobe_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int DIV_LO      = 16,
  parameter int DIV_HI      = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  ctrl_fields_t      ctrlIn,
  input  logic              statusRd,
  input  logic              reloadWr,
  input  logic [ADDR_W-1:0] byteSel,
  input  logic              extClkIn,
  input  logic              tcEvent,
  output strobe_t           strb,
  output logic              irqEn,
  output logic              pendingFlag,
  output logic              pinOut
);
  localparam int PRE_W = $clog2(DIV_HI);
  localparam logic [PRE_W-1:0] LO_MASK = PRE_W'(DIV_LO - 1);
  localparam logic [PRE_W-1:0] HI_LAST = PRE_W'(DIV_HI - 1);

  logic [PRE_W-1:0]       presc;
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncPrev;
  logic                   extNow, extRise, extFall;
  logic                   divTickLo, divTickHi, tick;
  logic                   autoReload, countUp;
  clk_sel_e               clkSel;

  // prescaler restarts on every control write
  always_ff @(posedge clk) begin
    if (!rstN)       presc <= '0;
    else if (ctrlWr) presc <= '0;
    else             presc <= presc + 1'b1;
  end

  assign divTickLo = (presc & LO_MASK) == LO_MASK;
  assign divTickHi = presc == HI_LAST;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_multi
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], extClkIn};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= extClkIn;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) syncPrev <= 1'b0;
    else       syncPrev <= extNow;
  end

  assign extNow  = syncChain[SYNC_STAGES-1];
  assign extRise = extNow & ~syncPrev;
  assign extFall = ~extNow & syncPrev;

  always_comb begin
    unique case (clkSel)
      SEL_DIV_LO:   tick = divTickLo;
      SEL_DIV_HI:   tick = divTickHi;
      SEL_EXT_RISE: tick = extRise;
      default:      tick = extFall;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn      <= 1'b0;
      autoReload <= 1'b0;
      countUp    <= 1'b0;
      clkSel     <= SEL_DIV_LO;
      pinOut     <= 1'b0;
    end else if (ctrlWr) begin
      irqEn      <= ctrlIn.irqEn;
      autoReload <= ctrlIn.autoReload;
      countUp    <= ctrlIn.countUp;
      clkSel     <= ctrlIn.clkSel;
      pinOut     <= ctrlIn.pinLevel;
    end else if (tcEvent) begin
      pinOut     <= ~pinOut;
    end
  end

  // a new terminal count wins over the acknowledge
  always_ff @(posedge clk) begin
    if (!rstN)         pendingFlag <= 1'b0;
    else if (tcEvent)  pendingFlag <= 1'b1;
    else if (statusRd) pendingFlag <= 1'b0;
  end

  always_comb begin
    strb.tick       = tick;
    strb.loadNow    = ctrlWr & ctrlIn.loadNow;
    strb.countUp    = countUp;
    strb.autoReload = autoReload;
    strb.reloadWr   = reloadWr;
    strb.byteSel    = byteSel;
  end
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [7:0]       wrData,
  output logic [CNT_W-1:0] count,
  output logic             tcEvent
);
  localparam int NUM_BYTES = CNT_W / 8;

  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] stepped;

  assign stepped = strb.countUp ? count + 1'b1 : count - 1'b1;
  assign tcEvent = strb.tick && !strb.loadNow && (stepped == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal <= '0;
    end else if (strb.reloadWr) begin
      for (int b = 0; b < NUM_BYTES; b++) begin
        if (strb.byteSel == ADDR_W'(b)) reloadVal[8*b +: 8] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              count <= '0;
    else if (strb.loadNow)                  count <= reloadVal;
    else if (tcEvent && strb.autoReload)    count <= reloadVal;
    else if (strb.tick)                     count <= stepped;
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int DIV_LO      = 16,
  parameter int DIV_HI      = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              extClkIn,
  output logic              pinOut,
  output logic              irqOut
);
  localparam int NUM_BYTES = CNT_W / 8;

  ctrl_fields_t     ctrlIn;
  strobe_t          strb;
  logic             ctrlWr, statusRd, reloadWr;
  logic             tcEvent, irqEn, pendingFlag;
  logic [CNT_W-1:0] count;

  assign ctrlWr   = busWrEn && (busAddr == ADDR_CTRL);
  assign reloadWr = busWrEn && (busAddr != ADDR_CTRL);
  assign statusRd = busRdEn && (busAddr == ADDR_CTRL);

  always_comb begin
    ctrlIn.irqEn      = busWrData[BIT_IRQ_EN];
    ctrlIn.loadNow    = busWrData[BIT_LOAD_NOW];
    ctrlIn.autoReload = busWrData[BIT_AUTO];
    ctrlIn.countUp    = busWrData[BIT_UP];
    ctrlIn.pinLevel   = busWrData[BIT_PIN];
    ctrlIn.clkSel     = clk_sel_e'({busWrData[BIT_SEL_HI], busWrData[BIT_SEL_LO]});
  end

  timer_ctrl #(
    .DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlIn(ctrlIn),
    .statusRd(statusRd), .reloadWr(reloadWr), .byteSel(busAddr),
    .extClkIn(extClkIn), .tcEvent(tcEvent), .strb(strb),
    .irqEn(irqEn), .pendingFlag(pendingFlag), .pinOut(pinOut)
  );

  timer_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData),
    .count(count), .tcEvent(tcEvent)
  );

  always_comb begin
    busRdData = {irqEn, 6'b0, pendingFlag};
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (busAddr == ADDR_W'(b)) busRdData = count[8*b +: 8];
    end
  end

  assign irqOut = irqEn && pendingFlag;
endmodule

// File: rtl/interval_timer_checker.sv
module interval_timer_checker
  import timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRdEn,
  input logic              ctrlWr,
  input logic              pinOut,
  input logic              tcEvent,
  input logic              tick,
  input logic              loadNow,
  input logic              countUp,
  input logic              pendingFlag,
  input logic [CNT_W-1:0]  count
);
  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_CTRL && !tcEvent) |=> !pendingFlag);

  p_tc_sets_pending_r12: assert property (@(posedge clk) disable iff (!rstN)
    tcEvent |=> pendingFlag);

  p_pin_toggles_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tcEvent && !ctrlWr) |=> (pinOut != $past(pinOut)));

  p_count_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !loadNow) |=> $stable(count));

  p_up_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !loadNow && countUp && !tcEvent) |=> (count == CNT_W'($past(count) + 1)));
endmodule

bind interval_timer interval_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdEn(busRdEn),
  .ctrlWr(ctrlWr), .pinOut(pinOut), .tcEvent(tcEvent),
  .tick(strb.tick), .loadNow(strb.loadNow), .countUp(strb.countUp),
  .pendingFlag(pendingFlag), .count(count)
);

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       extClkIn = 1'b0;
  logic       pinOut, irqOut;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t expQ[$];

  interval_timer u_interval_timer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .extClkIn(extClkIn), .pinOut(pinOut), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  // monitor: pops expected read data and compares away from the edge
  always @(negedge clk) begin
    if (rstN && busRdEn) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL unexpected read: actual %02h expected none", busRdData);
      end else begin
        item_t it;
        it = expQ.pop_front();
        if (busRdData !== it.exp) begin
          nFails++;
          $display("FAIL %s addr %0d: actual %02h expected %02h", it.tag, busAddr, busRdData, it.exp);
        end
      end
    end
  end

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.exp = e; it.tag = tag;
    expQ.push_back(it);
    busAddr = a; busRdEn = 1'b1;
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic checkBit(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic extSet(input logic v);
    @(posedge clk); #1;
    extClkIn = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic extPulse();
    extSet(1'b1);
    extSet(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    checkBit("R1 pinOut", pinOut, 1'b0);
    checkBit("R1 irqOut", irqOut, 1'b0);
    for (int a = 0; a < 4; a++) busRead(2'(a), 8'h00, "R1");

    // R2 reload writes leave counter alone
    busWrite(2'd0, 8'h03);
    busWrite(2'd1, 8'h00);
    busWrite(2'd2, 8'h00);
    busRead(2'd0, 8'h00, "R2");

    // R4 reload now; irq, auto, rising, down
    busWrite(2'd3, 8'hE1);
    busRead(2'd0, 8'h03, "R4");
    busRead(2'd1, 8'h00, "R3");
    busRead(2'd2, 8'h00, "R3");
    busRead(2'd3, 8'h80, "R11 status after load");

    // R6 rising counted, falling ignored
    extSet(1'b1);
    busRead(2'd0, 8'h02, "R6 rise");
    extSet(1'b0);
    busRead(2'd0, 8'h02, "R6 fall ignored");
    extPulse();
    extSet(1'b1);
    // R8 terminal with auto reload
    busRead(2'd0, 8'h03, "R8 autoreload");
    checkBit("R9 toggle", pinOut, 1'b1);
    checkBit("R10 irq", irqOut, 1'b1);
    extSet(1'b0);
    busRead(2'd3, 8'h81, "R11 pending");
    busRead(2'd3, 8'h80, "R11 cleared");
    checkBit("R11 irq cleared", irqOut, 1'b0);

    // R10 irq disabled still counts and flags
    busWrite(2'd3, 8'h21);
    checkBit("R9 written", pinOut, 1'b0);
    extPulse(); extPulse(); extPulse();
    checkBit("R10 gated", irqOut, 1'b0);
    checkBit("R9 toggle 2", pinOut, 1'b1);
    busRead(2'd3, 8'h01, "R10 pending without enable");
    busRead(2'd0, 8'h03, "R8 reload again");

    // R7 up count, falling edges, no auto reload
    busWrite(2'd0, 8'hFE);
    busWrite(2'd1, 8'hFF);
    busWrite(2'd2, 8'hFF);
    busWrite(2'd3, 8'h59);
    busRead(2'd2, 8'hFF, "R3 high byte");
    busRead(2'd0, 8'hFE, "R4 up load");
    extSet(1'b1);
    busRead(2'd0, 8'hFE, "R6 rise ignored");
    extSet(1'b0);
    busRead(2'd0, 8'hFF, "R7 up step");
    extPulse();
    busRead(2'd0, 8'h00, "R7 wrap");
    busRead(2'd2, 8'h00, "R8 no reload");
    checkBit("R9 toggle up", pinOut, 1'b1);
    busRead(2'd3, 8'h01, "R10 pending up");
    extPulse();
    busRead(2'd0, 8'h01, "R8 keeps counting");

    // R12 status read in the terminal-count cycle
    busWrite(2'd0, 8'h01);
    busWrite(2'd1, 8'h00);
    busWrite(2'd2, 8'h00);
    busWrite(2'd3, 8'hC1);
    @(posedge clk); #1;
    extClkIn = 1'b1;
    @(posedge clk); #1;
    busRead(2'd3, 8'h80, "R12 collide read");
    checkBit("R12 irq kept", irqOut, 1'b1);
    busRead(2'd3, 8'h81, "R12 pending kept");
    extSet(1'b0);

    // R5 divide by 16
    busWrite(2'd0, 8'h05);
    busWrite(2'd3, 8'h40);
    repeat (20) @(posedge clk);
    busRead(2'd0, 8'h04, "R5 div16 first");
    repeat (16) @(posedge clk);
    busRead(2'd0, 8'h03, "R5 div16 second");

    // R5 divide by 256
    busWrite(2'd3, 8'h50);
    repeat (250) @(posedge clk);
    busRead(2'd0, 8'h05, "R5 div256 before");
    repeat (8) @(posedge clk);
    busRead(2'd0, 8'h04, "R5 div256 after");

    repeat (2) @(posedge clk);
    if (expQ.size() != 0) begin
      nChecks++;
      nFails++;
      $display("FAIL scoreboard: actual %0d left expected 0", expQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule